// File: doc/BRIEF.md
# 1-Wire Bit and Byte Slot Generator

This block turns a single start strobe into correctly timed 1-Wire time slots. It pulls the bus low, releases it, and samples the synchronized bus level, so the controller above it never deals with microsecond timing. Each slot is a write-0 slot or a write-1 slot. A read is a write-1 slot whose sampled level is kept. In bit mode one slot runs. In byte mode eight slots run back to back, least significant bit first.

Segment lengths come from a table chosen by the speed select. At flexible speed three 3-bit fields stretch the write-1 low time, the sample offset and the write-0 recovery time. The flexible fields, the speed, the mode and the transmit byte are latched when a start is accepted. The block counts time in clock cycles, with `TICKS_PER_US` cycles per microsecond.

Top module: `owslot_gen`

## Requirements
- R1: While reset is active and right after it, pullLow, done and rxData are all 0.
- R2: When start is sampled high with no transfer running, pullLow goes high in the next cycle. A start sampled while a transfer runs is ignored.
- R3: A write-1 slot is pulled low, then released for the sample offset, then released for the high time. Speed code 0 (regular) gives 8, 3 and 49 µs. Code 1 (overdrive) gives 1, 1 and 8 µs. Code 3 behaves exactly as code 0.
- R4: A write-0 slot is pulled low, then released for the recovery time. Regular speed gives 57 µs and 3 µs. Overdrive gives 7 µs and 3 µs.
- R5: At speed code 2 (flexible), a write-1 slot is low for 8+flexLow µs, samples after 3+flexSamp µs and stays high for 49 µs. A write-0 slot is low for 57 µs and recovers for 3+flexRec µs.
- R6: In a write-1 slot the bus is sampled in the last cycle of the sample offset, and that level is stored as the received bit. A write-0 slot stores 0.
- R7: With byteMode=1, eight slots run with zero idle cycles between them. They send txData bit 0 first, and received bit k lands in rxData[k]. With byteMode=0, one slot sends txData[0], its result lands in rxData[0], and rxData[7:1] is 0.
- R8: done is high for exactly one cycle: the cycle right after the last slot ends, with pullLow low. rxData then holds the result until the next start is accepted.
- R9: The speed, the mode, txData and the flexible fields are taken at the accepted start. Changing them during a transfer has no effect on that transfer.
- R10: A start sampled in the done cycle is accepted, and the first slot of the new transfer pulls low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| byteMode | input | 1 | 1 = eight slots, 0 = one slot |
| txData | input | 8 | Bits to send, bit 0 first |
| speed | input | 2 | 0 regular, 1 overdrive, 2 flexible, 3 regular |
| flexLow | input | 3 | Flexible write-1 low extension, µs |
| flexSamp | input | 3 | Flexible sample-offset extension, µs |
| flexRec | input | 3 | Flexible write-0 recovery extension, µs |
| busIn | input | 1 | Synchronized bus level |
| pullLow | output | 1 | Drive the bus low |
| rxData | output | 8 | Received bits |
| done | output | 1 | One-cycle completion strobe |

## Verification
End of transfer and acceptance of a new start can fall in the same cycle. In that cycle the controller reports done and is also ready to take a start. The bench holds start high through a whole byte transfer and changes the configuration in the done cycle. It then checks three things: the running transfer was never restarted, done appeared exactly once, and the new slot pulled low in the very next cycle with the new configuration. A second collision, bus release against the sampling edge, is covered by moving the slave's release one cycle on either side of the last sample-offset cycle.

// File: rtl/owslot_pkg.sv
package owslot_pkg;

  typedef enum logic [1:0] {
    SPD_REGULAR  = 2'd0,
    SPD_OVERDRV  = 2'd1,
    SPD_FLEX     = 2'd2,
    SPD_ALTREG   = 2'd3
  } speedT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_SAMP = 2'd2,
    ST_HIGH = 2'd3
  } slotStateT;

  typedef struct packed {
    logic capture;
    logic sample;
    logic advance;
  } slotStrobeT;

endpackage

// File: rtl/owslot_datapath.sv
module owslot_datapath
  import owslot_pkg::*;
#(
  parameter int TICKS_PER_US = 50,
  parameter int CNT_W        = 12,
  parameter int DATA_W       = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  slotStrobeT             strobe,
  input  logic                   byteMode,
  input  logic [DATA_W-1:0]      txData,
  input  logic [1:0]             speed,
  input  logic [2:0]             flexLow,
  input  logic [2:0]             flexSamp,
  input  logic [2:0]             flexRec,
  input  logic                   busIn,
  output logic                   curBit,
  output logic                   lastSlot,
  output logic [CNT_W-1:0]       lowLen,
  output logic [CNT_W-1:0]       sampLen,
  output logic [CNT_W-1:0]       highLen,
  output logic [DATA_W-1:0]      rxData
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] TPU_C = CNT_W'(TICKS_PER_US);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] txQ;
  logic [DATA_W-1:0] rxQ;
  logic              modeQ;
  speedT             speedQ;
  logic [2:0]        flLowQ, flSampQ, flRecQ;
  logic [IDX_W-1:0]  idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ     <= '0;
      rxQ     <= '0;
      modeQ   <= 1'b0;
      speedQ  <= SPD_REGULAR;
      flLowQ  <= '0;
      flSampQ <= '0;
      flRecQ  <= '0;
      idxQ    <= '0;
    end else if (strobe.capture) begin
      txQ     <= txData;
      rxQ     <= '0;
      modeQ   <= byteMode;
      speedQ  <= speedT'(speed);
      flLowQ  <= flexLow;
      flSampQ <= flexSamp;
      flRecQ  <= flexRec;
      idxQ    <= '0;
    end else begin
      if (strobe.sample)  rxQ[idxQ] <= busIn;
      if (strobe.advance) idxQ <= idxQ + 1'b1;
    end
  end

  assign curBit   = txQ[idxQ];
  assign lastSlot = !modeQ || (idxQ == LAST_IDX);
  assign rxData   = rxQ;

  logic isOd, isFlex;
  logic [6:0] lowUs, sampUs, highUs;

  always_comb begin
    isOd   = (speedQ == SPD_OVERDRV);
    isFlex = (speedQ == SPD_FLEX);
    if (curBit) begin
      lowUs  = isOd ? 7'd1 : (isFlex ? 7'd8 + {4'd0, flLowQ} : 7'd8);
      highUs = isOd ? 7'd8 : 7'd49;
    end else begin
      lowUs  = isOd ? 7'd7 : 7'd57;
      highUs = isFlex ? 7'd3 + {4'd0, flRecQ} : 7'd3;
    end
    sampUs = isOd ? 7'd1 : (isFlex ? 7'd3 + {4'd0, flSampQ} : 7'd3);
  end

  assign lowLen  = CNT_W'(lowUs)  * TPU_C;
  assign sampLen = CNT_W'(sampUs) * TPU_C;
  assign highLen = CNT_W'(highUs) * TPU_C;

endmodule

// File: rtl/owslot_control.sv
module owslot_control
  import owslot_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              curBit,
  input  logic              lastSlot,
  input  logic [CNT_W-1:0]  lowLen,
  input  logic [CNT_W-1:0]  sampLen,
  input  logic [CNT_W-1:0]  highLen,
  output slotStrobeT        strobe,
  output logic              pullLow,
  output logic              done
);

  slotStateT        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curLen;
  logic             segEnd;

  always_comb begin
    unique case (state)
      ST_LOW:  curLen = lowLen;
      ST_SAMP: curLen = sampLen;
      default: curLen = highLen;
    endcase
    segEnd = (state != ST_IDLE) && (cnt == curLen - CNT_W'(1));
    strobe = '0;
    strobe.capture = (state == ST_IDLE) && start;
    strobe.sample  = (state == ST_SAMP) && segEnd;
    strobe.advance = (state == ST_HIGH) && segEnd && !lastSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_LOW;
            cnt   <= '0;
          end
        end
        ST_LOW: begin
          if (segEnd) begin
            cnt   <= '0;
            state <= curBit ? ST_SAMP : ST_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        ST_SAMP: begin
          if (segEnd) begin
            cnt   <= '0;
            state <= ST_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        ST_HIGH: begin
          if (segEnd) begin
            cnt <= '0;
            if (lastSlot) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else state <= ST_LOW;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign pullLow = (state == ST_LOW);

endmodule

// File: rtl/owslot_gen.sv
module owslot_gen
  import owslot_pkg::*;
#(
  parameter int TICKS_PER_US = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       byteMode,
  input  logic [7:0] txData,
  input  logic [1:0] speed,
  input  logic [2:0] flexLow,
  input  logic [2:0] flexSamp,
  input  logic [2:0] flexRec,
  input  logic       busIn,
  output logic       pullLow,
  output logic [7:0] rxData,
  output logic       done
);

  localparam int CNT_W = $clog2(64 * TICKS_PER_US + 1);

  slotStrobeT       strobe;
  logic             curBit, lastSlot;
  logic [CNT_W-1:0] lowLen, sampLen, highLen;

  owslot_control #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .curBit(curBit), .lastSlot(lastSlot),
    .lowLen(lowLen), .sampLen(sampLen), .highLen(highLen),
    .strobe(strobe), .pullLow(pullLow), .done(done)
  );

  owslot_datapath #(.TICKS_PER_US(TICKS_PER_US), .CNT_W(CNT_W), .DATA_W(8)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .byteMode(byteMode), .txData(txData), .speed(speed),
    .flexLow(flexLow), .flexSamp(flexSamp), .flexRec(flexRec),
    .busIn(busIn), .curBit(curBit), .lastSlot(lastSlot),
    .lowLen(lowLen), .sampLen(sampLen), .highLen(highLen),
    .rxData(rxData)
  );

endmodule

// File: rtl/owslot_gen_chk.sv
module owslot_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       pullLow,
  input logic       done,
  input logic [7:0] rxData
);

  logic active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= (active && !done) || (start && (!active || done));
  end

  AST_START_PULLS: assert property (@(posedge clk) disable iff (!rstN)
    (start && (!active || done)) |=> pullLow);  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!pullLow && !done));  // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pullLow);  // R8

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !done) |-> $stable(rxData));  // R8

endmodule

bind owslot_gen owslot_gen_chk uChk (
  .clk(clk), .rstN(rstN), .start(start),
  .pullLow(pullLow), .done(done), .rxData(rxData)
);

// File: tb/owslot_gen_test.sv
module owslot_gen_test;

  localparam int TPU = 2;
  localparam int NVEC = 7;

  // speed, byteMode, tx, flexLow, flexSamp, flexRec, slave response
  localparam logic [27:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 8'hA5, 3'd0, 3'd0, 3'd0, 8'h3C},
    {2'd1, 1'b1, 8'h5A, 3'd0, 3'd0, 3'd0, 8'hF0},
    {2'd2, 1'b1, 8'hC3, 3'd7, 3'd7, 3'd7, 8'h0F},
    {2'd2, 1'b0, 8'h01, 3'd3, 3'd2, 3'd5, 8'hFE},
    {2'd3, 1'b1, 8'hFF, 3'd0, 3'd0, 3'd0, 8'h96},
    {2'd1, 1'b0, 8'h00, 3'd0, 3'd0, 3'd0, 8'hFF},
    {2'd2, 1'b1, 8'h00, 3'd0, 3'd0, 3'd0, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic byteMode = 1'b0;
  logic [7:0] txData = '0;
  logic [1:0] speed = '0;
  logic [2:0] flexLow = '0, flexSamp = '0, flexRec = '0;
  logic slaveLow = 1'b0;
  logic pullLow, done;
  logic [7:0] rxData;
  wire busIn = !(pullLow || slaveLow);

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  owslot_gen #(.TICKS_PER_US(TPU)) uut (
    .clk(clk), .rstN(rstN), .start(start), .byteMode(byteMode),
    .txData(txData), .speed(speed), .flexLow(flexLow), .flexSamp(flexSamp),
    .flexRec(flexRec), .busIn(busIn), .pullLow(pullLow), .rxData(rxData),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLow(input logic [1:0] sp, input logic b, input logic [2:0] fl);
    int us;
    if (b) us = (sp == 2'd1) ? 1 : (sp == 2'd2) ? 8 + fl : 8;
    else   us = (sp == 2'd1) ? 7 : 57;
    return us * TPU;
  endfunction

  function automatic int expTot(input logic [1:0] sp, input logic b,
                                input logic [2:0] fl, input logic [2:0] fs, input logic [2:0] fr);
    int us;
    if (b) us = (sp == 2'd1) ? 10 : (sp == 2'd2) ? 8 + fl + 3 + fs + 49 : 60;
    else   us = (sp == 2'd1) ? 10 : (sp == 2'd2) ? 60 + fr : 60;
    return us * TPU;
  endfunction

  // Called right after the negedge where start was set (or held) for an idle block.
  task automatic measure(input logic [1:0] sp, input logic md, input logic [7:0] tx,
                         input logic [2:0] fl, input logic [2:0] fs, input logic [2:0] fr,
                         input logic [7:0] resp, input int slaveMode, input int kRel,
                         input bit scramble, input bit dropStart, input string timeReq,
                         output logic [7:0] rxOut, output int slotsOut);
    int slots = 0, slotCyc = 0, lowCyc = 0, relIdx = 0, badSlots = 0, guard = 0;
    logic prevPl = 1'b0;
    @(negedge clk);
    if (dropStart) start = 1'b0;
    if (scramble) begin
      txData = ~tx; speed = sp ^ 2'b01; byteMode = ~md;
      flexLow = ~fl; flexSamp = ~fs; flexRec = ~fr;
    end
    check(pullLow === 1'b1, "R2 first slot pulls low next cycle", int'(pullLow), 1);
    forever begin
      if (done) begin
        if (slots > 0 && (lowCyc != expLow(sp, tx[slots-1], fl) ||
                          slotCyc != expTot(sp, tx[slots-1], fl, fs, fr))) badSlots++;
        break;
      end
      if (pullLow && !prevPl) begin
        if (slots > 0 && (lowCyc != expLow(sp, tx[slots-1], fl) ||
                          slotCyc != expTot(sp, tx[slots-1], fl, fs, fr))) badSlots++;
        slots++; slotCyc = 1; lowCyc = 1; relIdx = 0;
      end else begin
        slotCyc++;
        if (pullLow) lowCyc++;
      end
      if (slots > 0 && slots <= 8) begin
        if (slaveMode == 0) slaveLow = !resp[slots-1];
        else if (pullLow) slaveLow = 1'b1;
        else begin
          slaveLow = (relIdx < kRel);
          relIdx++;
        end
      end
      prevPl = pullLow;
      guard++;
      if (guard > 6000) begin
        check(1'b0, "R8 transfer never completed", guard, 0);
        break;
      end
      @(negedge clk);
    end
    slaveLow = 1'b0;
    check(badSlots == 0, timeReq, badSlots, 0);
    rxOut = rxData;
    slotsOut = slots;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int nSlots;
    repeat (3) @(negedge clk);
    check(pullLow === 1'b0 && done === 1'b0 && rxData === 8'h00, "R1 reset state",
          int'({pullLow, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pullLow === 1'b0 && done === 1'b0 && rxData === 8'h00, "R1 after reset",
          int'(rxData), 0);

    // Table-driven transfers; inputs are scrambled after the start (R9)
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] sp; logic md; logic [7:0] tx, resp, expRx;
      logic [2:0] fl, fs, fr;
      {sp, md, tx, fl, fs, fr, resp} = VEC[i];
      expRx = md ? (tx & resp) : {7'd0, tx[0] & resp[0]};
      speed = sp; byteMode = md; txData = tx;
      flexLow = fl; flexSamp = fs; flexRec = fr;
      start = 1'b1;
      measure(sp, md, tx, fl, fs, fr, resp, 0, 0, 1'b1, 1'b1,
              (sp == 2'd2) ? "R5 flexible slot timing" : "R3/R4 slot timing", rx, nSlots);
      check(rx === expRx, "R6/R9 received data", int'(rx), int'(expRx));
      check(nSlots == (md ? 8 : 1), "R7 slot count", nSlots, md ? 8 : 1);
      @(negedge clk);
      check(done === 1'b0 && pullLow === 1'b0, "R8 done lasts one cycle", int'(done), 0);
    end

    // R8: result held while idle
    repeat (5) @(negedge clk);
    check(rxData === 8'h00, "R8 rxData held after done", int'(rxData), 0);

    // R6: slave releases in the last sample-offset cycle -> reads 1
    speed = 2'd0; byteMode = 1'b0; txData = 8'h01; start = 1'b1;
    measure(2'd0, 1'b0, 8'h01, 3'd0, 3'd0, 3'd0, 8'h00, 1, 3 * TPU - 1, 1'b0, 1'b1,
            "R3 write-1 timing", rx, nSlots);
    check(rx === 8'h01, "R6 release at sample cycle reads 1", int'(rx), 1);
    repeat (3) @(negedge clk);
    // R6: slave releases one cycle later -> reads 0
    start = 1'b1;
    measure(2'd0, 1'b0, 8'h01, 3'd0, 3'd0, 3'd0, 8'h00, 1, 3 * TPU, 1'b0, 1'b1,
            "R3 write-1 timing", rx, nSlots);
    check(rx === 8'h00, "R6 release after sample cycle reads 0", int'(rx), 0);
    repeat (3) @(negedge clk);

    // R2/R10: start held through a byte transfer, then new config in the done cycle
    speed = 2'd0; byteMode = 1'b1; txData = 8'h0F; start = 1'b1;
    measure(2'd0, 1'b1, 8'h0F, 3'd0, 3'd0, 3'd0, 8'hFF, 0, 0, 1'b0, 1'b0,
            "R2 held start does not restart slots", rx, nSlots);
    check(nSlots == 8, "R2 start during transfer ignored", nSlots, 8);
    check(rx === 8'h0F, "R7 byte result with held start", int'(rx), 8'h0F);
    speed = 2'd1; byteMode = 1'b0; txData = 8'h01;
    measure(2'd1, 1'b0, 8'h01, 3'd0, 3'd0, 3'd0, 8'hFF, 0, 0, 1'b0, 1'b1,
            "R10 back-to-back transfer timing", rx, nSlots);
    check(nSlots == 1, "R10 start in done cycle accepted", nSlots, 1);
    check(rx === 8'h01, "R10 new transfer result", int'(rx), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule